// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit logical address into a 16-bit physical address by way of a four-entry segment table. The two top address bits pick an entry and the remaining twelve bits are an offset into that segment. Each entry carries a physical base, an offset limit, a read/write permission pair and a valid flag. For every request the block looks up the entry, checks that the entry is valid, checks the offset against the limit, checks the access type against the permissions, and then adds the base to the offset. The result is registered, so a response comes one cycle after its request.

The table is loaded through a configuration port. A write through that port lands only when the privileged input is high in the same cycle. This way code running in user mode cannot alter its own relocation or protection. After reset the table holds three usable segments and one unused segment.

Top module: `seg_xlate`

## Requirements
- R1: Logical address bits [13:12] select the segment and bits [11:0] form the offset. A legal access returns rsp_paddr = base + offset with rsp_fault = 00.
- R2: After reset the entries hold the following. Entry 0: base 0x4000, limit 0x06FF, read only (perm 10). Entry 1: base 0x0000, limit 0x04FF, perm 11. Entry 2: base 0x3000, limit 0x0FFF, perm 11. Entry 3: invalid.
- R3: An offset equal to the limit is legal. An offset above the limit gives fault code 01, and rsp_paddr is then 0. Whenever rsp_fault is nonzero, rsp_paddr is 0.
- R4: Perm bit 1 grants read and perm bit 0 grants write, with req_write = 1 marking a write. An access type whose bit is 0 gives fault code 10.
- R5: An access to an invalid entry gives fault code 11. The faults rank as follows: invalid entry first, then limit, then permission.
- R6: rsp_valid is high in exactly the cycle after each cycle with req_valid high, so back-to-back requests are each answered. While rsp_valid is low, rsp_paddr and rsp_fault are 0.
- R7: When cfg_we and priv are both high, entry cfg_idx takes cfg_base, cfg_limit, cfg_perm and cfg_valid at the clock edge. Requests from the next cycle onward see the new values, and a request in the same cycle sees the old ones.
- R8: A configuration write with priv low changes nothing in the table.
- R9: The base-plus-offset sum is truncated to 16 bits, and any carry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 14 | Logical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 none, 01 limit, 10 permission, 11 invalid entry |
| priv | input | 1 | Privileged mode; gates table writes |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 12 | New limit |
| cfg_perm | input | 2 | New permissions, bit 1 read, bit 0 write |
| cfg_valid | input | 1 | New valid flag |

## Verification
The bench uses the default parameters: a 14-bit logical address, two segment-select bits and a 16-bit physical address. With these values the reset table reaches every fault code and an offset exactly at a limit. A 16-bit result also lets a privileged write of a high base drive the sum past 0xFFFF, which exercises the dropped carry. Because the offset is 12 bits, the limit 0x0FFF in entry 2 covers the whole offset range, so that entry can never raise a limit fault.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_LIMIT = 2'b01,
      FLT_PROT  = 2'b10,
      FLT_INVAL = 2'b11
   } xl_fault_e;

   localparam int PERM_W      = 2;
   localparam int PERM_RD_BIT = 1;
   localparam int PERM_WR_BIT = 0;

   // Power-up image of the table, per entry index
   function automatic logic [31:0] rst_base(input int idx);
      case (idx)
         0:       return 32'h0000_4000;
         2:       return 32'h0000_3000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [31:0] rst_limit(input int idx);
      case (idx)
         0:       return 32'h0000_06FF;
         1:       return 32'h0000_04FF;
         2:       return 32'h0000_0FFF;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [PERM_W-1:0] rst_perm(input int idx);
      case (idx)
         0:       return 2'b10;
         1, 2:    return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic rst_valid(input int idx);
      return (idx < 3);
   endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
   import seg_xlate_pkg::*;
#(
   parameter int SEG_BITS = 2,
   parameter int OFF_W    = 12,
   parameter int PADDR_W  = 16,
   localparam int NSEG    = 1 << SEG_BITS
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            priv,
   input  logic                            cfg_we,
   input  logic [SEG_BITS-1:0]             cfg_idx,
   input  logic [PADDR_W-1:0]              cfg_base,
   input  logic [OFF_W-1:0]                cfg_limit,
   input  logic [PERM_W-1:0]               cfg_perm,
   input  logic                            cfg_valid,
   output logic [NSEG-1:0][PADDR_W-1:0]    tbl_base,
   output logic [NSEG-1:0][OFF_W-1:0]      tbl_limit,
   output logic [NSEG-1:0][PERM_W-1:0]     tbl_perm,
   output logic [NSEG-1:0]                 tbl_valid
);

   logic wr_ok;
   assign wr_ok = cfg_we & priv;

   for (genvar i = 0; i < NSEG; i++) begin : g_ent
      logic hit;
      assign hit = wr_ok && (cfg_idx == SEG_BITS'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tbl_base[i]  <= PADDR_W'(rst_base(i));
            tbl_limit[i] <= OFF_W'(rst_limit(i));
            tbl_perm[i]  <= rst_perm(i);
            tbl_valid[i] <= rst_valid(i);
         end else if (hit) begin
            tbl_base[i]  <= cfg_base;
            tbl_limit[i] <= cfg_limit;
            tbl_perm[i]  <= cfg_perm;
            tbl_valid[i] <= cfg_valid;
         end
      end
   end

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int SEG_BITS = 2,
   parameter int OFF_W    = 12,
   parameter int PADDR_W  = 16,
   localparam int NSEG    = 1 << SEG_BITS
) (
   input  logic [SEG_BITS-1:0]             seg,
   input  logic [OFF_W-1:0]                off,
   input  logic                            is_write,
   input  logic [NSEG-1:0][PADDR_W-1:0]    tbl_base,
   input  logic [NSEG-1:0][OFF_W-1:0]      tbl_limit,
   input  logic [NSEG-1:0][PERM_W-1:0]     tbl_perm,
   input  logic [NSEG-1:0]                 tbl_valid,
   output logic [PADDR_W-1:0]              paddr,
   output xl_fault_e                       fault
);

   logic [PADDR_W-1:0] e_base;
   logic [OFF_W-1:0]   e_limit;
   logic [PERM_W-1:0]  e_perm;
   logic               e_valid;
   logic               over, denied;

   assign e_base  = tbl_base[seg];
   assign e_limit = tbl_limit[seg];
   assign e_perm  = tbl_perm[seg];
   assign e_valid = tbl_valid[seg];

   assign over   = off > e_limit;
   assign denied = is_write ? !e_perm[PERM_WR_BIT] : !e_perm[PERM_RD_BIT];

   always_comb begin
      if (!e_valid)    fault = FLT_INVAL;
      else if (over)   fault = FLT_LIMIT;
      else if (denied) fault = FLT_PROT;
      else             fault = FLT_NONE;
   end

   // Sum kept to PADDR_W bits: carry out is discarded
   assign paddr = (fault == FLT_NONE) ? PADDR_W'(e_base + PADDR_W'(off)) : '0;

endmodule

// File: rtl/seg_resp.sv
module seg_resp
   import seg_xlate_pkg::*;
#(
   parameter int PADDR_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PADDR_W-1:0] in_paddr,
   input  xl_fault_e          in_fault,
   output logic               out_valid,
   output logic [PADDR_W-1:0] out_paddr,
   output logic [1:0]         out_fault
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_fault <= FLT_NONE;
      end else begin
         out_valid <= in_valid;
         out_paddr <= in_valid ? in_paddr : '0;
         out_fault <= in_valid ? in_fault : FLT_NONE;
      end
   end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int LADDR_W  = 14,
   parameter int SEG_BITS = 2,
   parameter int PADDR_W  = 16,
   localparam int OFF_W   = LADDR_W - SEG_BITS,
   localparam int NSEG    = 1 << SEG_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [LADDR_W-1:0]  req_addr,
   input  logic                req_write,
   output logic                rsp_valid,
   output logic [PADDR_W-1:0]  rsp_paddr,
   output logic [1:0]          rsp_fault,
   input  logic                priv,
   input  logic                cfg_we,
   input  logic [SEG_BITS-1:0] cfg_idx,
   input  logic [PADDR_W-1:0]  cfg_base,
   input  logic [OFF_W-1:0]    cfg_limit,
   input  logic [1:0]          cfg_perm,
   input  logic                cfg_valid
);

   if (SEG_BITS < 1 || SEG_BITS > 4) begin : g_bad_seg
      $error("seg_xlate: SEG_BITS must be 1..4");
   end
   if (OFF_W < 1) begin : g_bad_off
      $error("seg_xlate: LADDR_W must exceed SEG_BITS");
   end
   if (PADDR_W <= OFF_W) begin : g_bad_pa
      $error("seg_xlate: PADDR_W must exceed the offset width");
   end

   logic [NSEG-1:0][PADDR_W-1:0] tbl_base;
   logic [NSEG-1:0][OFF_W-1:0]   tbl_limit;
   logic [NSEG-1:0][PERM_W-1:0]  tbl_perm;
   logic [NSEG-1:0]              tbl_valid;
   logic [SEG_BITS-1:0]          seg;
   logic [OFF_W-1:0]             off;
   logic [PADDR_W-1:0]           xl_paddr;
   xl_fault_e                    xl_fault;

   assign seg = req_addr[LADDR_W-1 -: SEG_BITS];
   assign off = req_addr[OFF_W-1:0];

   seg_table #(.SEG_BITS(SEG_BITS), .OFF_W(OFF_W), .PADDR_W(PADDR_W)) u_table (
      .clk(clk), .rst_n(rst_n), .priv(priv),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid),
      .tbl_base(tbl_base), .tbl_limit(tbl_limit),
      .tbl_perm(tbl_perm), .tbl_valid(tbl_valid)
   );

   seg_check #(.SEG_BITS(SEG_BITS), .OFF_W(OFF_W), .PADDR_W(PADDR_W)) u_check (
      .seg(seg), .off(off), .is_write(req_write),
      .tbl_base(tbl_base), .tbl_limit(tbl_limit),
      .tbl_perm(tbl_perm), .tbl_valid(tbl_valid),
      .paddr(xl_paddr), .fault(xl_fault)
   );

   seg_resp #(.PADDR_W(PADDR_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_paddr(xl_paddr), .in_fault(xl_fault),
      .out_valid(rsp_valid), .out_paddr(rsp_paddr), .out_fault(rsp_fault)
   );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
   import seg_xlate_pkg::*;
#(
   parameter int LADDR_W  = 14,
   parameter int SEG_BITS = 2,
   parameter int PADDR_W  = 16,
   localparam int OFF_W   = LADDR_W - SEG_BITS,
   localparam int NSEG    = 1 << SEG_BITS
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic [LADDR_W-1:0]           req_addr,
   input logic                         rsp_valid,
   input logic [PADDR_W-1:0]           rsp_paddr,
   input logic [1:0]                   rsp_fault,
   input logic                         priv,
   input logic                         cfg_we,
   input logic [NSEG-1:0][OFF_W-1:0]   tbl_limit,
   input logic [NSEG-1:0][PERM_W-1:0]  tbl_perm,
   input logic [NSEG-1:0]              tbl_valid
);

   logic [SEG_BITS-1:0] c_seg;
   logic [OFF_W-1:0]    c_off;
   assign c_seg = req_addr[LADDR_W-1 -: SEG_BITS];
   assign c_off = req_addr[OFF_W-1:0];

   a_r6_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_fault == 2'b00 && rsp_paddr == '0));

   a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);

   a_r3_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tbl_valid[c_seg] && c_off > tbl_limit[c_seg])
      |=> rsp_fault == 2'b01);

   a_r5_invalid_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !tbl_valid[c_seg]) |=> rsp_fault == 2'b11);

   a_r8_user_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !priv) |=>
      ($stable(tbl_limit) && $stable(tbl_perm) && $stable(tbl_valid)));

endmodule

bind seg_xlate seg_xlate_chk #(
   .LADDR_W(LADDR_W), .SEG_BITS(SEG_BITS), .PADDR_W(PADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
   .priv(priv), .cfg_we(cfg_we),
   .tbl_limit(tbl_limit), .tbl_perm(tbl_perm), .tbl_valid(tbl_valid)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [13:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [15:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        priv = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [15:0] cfg_base = '0;
   logic [11:0] cfg_limit = '0;
   logic [1:0]  cfg_perm = '0;
   logic        cfg_valid = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   seg_xlate uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .priv(priv), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid)
   );

   // {addr[13:0], write, expected paddr[15:0], expected fault[1:0]}
   localparam int NV = 12;
   localparam logic [32:0] VEC [NV] = '{
      {14'h0240, 1'b0, 16'h4240, 2'b00},   // R1 entry 0 read
      {14'h0240, 1'b1, 16'h0000, 2'b10},   // R4 write to read-only
      {14'h1108, 1'b0, 16'h0108, 2'b00},   // R1 entry 1
      {14'h265C, 1'b0, 16'h365C, 2'b00},   // R1 entry 2
      {14'h3002, 1'b0, 16'h0000, 2'b11},   // R5 invalid entry 3
      {14'h2A00, 1'b1, 16'h3A00, 2'b00},   // R2 entry 2 writable
      {14'h06FF, 1'b0, 16'h46FF, 2'b00},   // R3 offset == limit
      {14'h0700, 1'b0, 16'h0000, 2'b01},   // R3 offset over limit
      {14'h0700, 1'b1, 16'h0000, 2'b01},   // R5 limit before permission
      {14'h1500, 1'b1, 16'h0000, 2'b01},   // R3 entry 1 over limit
      {14'h14FF, 1'b1, 16'h04FF, 2'b00},   // R2 entry 1 writable at limit
      {14'h3FFF, 1'b1, 16'h0000, 2'b11}    // R5 invalid before limit
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic p, input logic [1:0] idx, input logic [15:0] b,
                            input logic [11:0] l, input logic [1:0] pm, input logic v);
      @(negedge clk);
      priv = p; cfg_we = 1'b1; cfg_idx = idx; cfg_base = b;
      cfg_limit = l; cfg_perm = pm; cfg_valid = v;
      @(negedge clk);
      cfg_we = 1'b0; priv = 1'b0;
   endtask

   // one request, response checked on the following falling edge
   task automatic one_req(input string tag, input logic [13:0] a, input logic w,
                          input logic [15:0] ep, input logic [1:0] ef);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " paddr"}, 32'(rsp_paddr), 32'(ep));
      check({tag, " fault"}, 32'(rsp_fault), 32'(ef));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R6 reset valid", 32'(rsp_valid), 32'd0);
      check("R6 reset paddr", 32'(rsp_paddr), 32'd0);
      rst_n = 1'b1;

      // back-to-back walk of the vector table
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check($sformatf("R6 vec%0d valid", i-1), 32'(rsp_valid), 32'd1);
            check($sformatf("R1 vec%0d paddr", i-1), 32'(rsp_paddr), 32'(VEC[i-1][17:2]));
            check($sformatf("R3 vec%0d fault", i-1), 32'(rsp_fault), 32'(VEC[i-1][1:0]));
         end
         if (i < NV) begin
            req_valid = 1'b1;
            req_addr  = VEC[i][32:19];
            req_write = VEC[i][18];
         end else begin
            req_valid = 1'b0;
         end
      end

      // idle: no response, outputs zero
      @(negedge clk);
      check("R6 idle valid", 32'(rsp_valid), 32'd0);
      check("R6 idle paddr", 32'(rsp_paddr), 32'd0);
      check("R6 idle fault", 32'(rsp_fault), 32'd0);

      // user-mode write attempt leaves entry 3 invalid and entry 0 intact
      cfg_write(1'b0, 2'd3, 16'h1000, 12'hFFF, 2'b11, 1'b1);
      cfg_write(1'b0, 2'd0, 16'h8000, 12'hFFF, 2'b11, 1'b1);
      one_req("R8 entry3 untouched", 14'h3002, 1'b0, 16'h0000, 2'b11);
      one_req("R8 entry0 untouched", 14'h0800, 1'b0, 16'h0000, 2'b01);
      one_req("R8 entry0 still ro", 14'h0010, 1'b1, 16'h0000, 2'b10);

      // privileged write takes effect
      cfg_write(1'b1, 2'd3, 16'h1000, 12'hFFF, 2'b11, 1'b1);
      one_req("R7 entry3 loaded", 14'h3002, 1'b1, 16'h1002, 2'b00);

      // same-cycle request sees old entry, next request sees new
      @(negedge clk);
      priv = 1'b1; cfg_we = 1'b1; cfg_idx = 2'd1; cfg_base = 16'h2000;
      cfg_limit = 12'h0FF; cfg_perm = 2'b01; cfg_valid = 1'b1;
      req_valid = 1'b1; req_addr = 14'h1108; req_write = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; priv = 1'b0;
      check("R7 old entry paddr", 32'(rsp_paddr), 32'h0108);
      check("R7 old entry fault", 32'(rsp_fault), 32'd0);
      req_addr = 14'h1080; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 new entry no read", 32'(rsp_fault), 32'(2'b10));
      one_req("R7 new entry write", 14'h1080, 1'b1, 16'h2080, 2'b00);
      one_req("R3 new limit", 14'h1100, 1'b1, 16'h0000, 2'b01);

      // carry out of the sum is dropped
      cfg_write(1'b1, 2'd3, 16'hF800, 12'hFFF, 2'b11, 1'b1);
      one_req("R9 wrap", 14'h3900, 1'b0, 16'h0100, 2'b00);

      // invalidating an entry
      cfg_write(1'b1, 2'd2, 16'h3000, 12'hFFF, 2'b11, 1'b0);
      one_req("R5 cleared entry", 14'h2000, 1'b0, 16'h0000, 2'b11);

      // reset restores the power-up image
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      one_req("R2 entry1 restored", 14'h1108, 1'b0, 16'h0108, 2'b00);
      one_req("R2 entry2 restored", 14'h2FFF, 1'b0, 16'h3FFF, 2'b00);
      one_req("R2 entry3 invalid", 14'h3000, 1'b0, 16'h0000, 2'b11);

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule